// File: doc/BRIEF.md
# Core Idle Power-State Sequencer

This block decides how deeply a processor core sleeps while it is idle, and when its vector coprocessor unit is powered. On request the core drops from the run state into a light idle state. A delay timer then counts time-base ticks, and it starts only once the light state has been entered. If the programmed number of ticks goes by with no wake condition, the core moves on by itself into the deeper idle state. A wake condition in either idle state sends the core back to run and clears the timer.

A second, independent controller watches the vector unit. Every clock cycle without a vector instruction advances an inactivity counter. When that counter reaches the programmed limit, the unit's power-enable is dropped with no software involvement. An instruction arriving while the unit is off raises power-enable again at once. It also holds a busy flag for a fixed wake latency, so that issue logic can stall until the unit is usable.

Top module: `idle_pwr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, core_state is run (2'b00), vec_pwr_en is 1 and vec_busy is 0.
- R2: In run (2'b00), idle_req high with wake_evt low moves core_state to light idle (2'b01) at the next clock edge. Time-base ticks seen while in run are not counted.
- R3: In light idle with deep_delay = D > 0 and no wake_evt, core_state becomes deep idle (2'b10) at the clock edge that samples the D-th tb_tick counted since light idle was entered.
- R4: wake_evt high in light or deep idle returns core_state to run at the next edge, even if a tick arrives in the same cycle. It also clears the tick count, so a later light idle needs the full D ticks again.
- R5: With deep_delay = 0, the core stays in light idle whatever the number of ticks, until wake_evt.
- R6: In run, wake_evt high takes priority over idle_req: the core stays in run.
- R7: With vec_idle_limit = N > 0, vec_pwr_en falls at the N-th consecutive clock edge that samples vec_issue low, and not before.
- R8: Every vec_issue pulse while the unit is powered and not busy restarts the inactivity count from zero.
- R9: With vec_idle_limit = 0, the vector unit is never powered down.
- R10: vec_issue while vec_pwr_en is 0 sets vec_pwr_en and vec_busy at the next edge. vec_busy stays high for exactly WAKE_LAT cycles (default 4). The inactivity count restarts from zero when vec_busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_tick | input | 1 | Time-base tick, one cycle per tick |
| deep_delay | input | DLY_W | Ticks spent in light idle before deep idle; 0 disables |
| idle_req | input | 1 | Request to enter light idle |
| wake_evt | input | 1 | Exit condition; returns the core to run |
| vec_issue | input | 1 | A vector instruction executed this cycle |
| vec_idle_limit | input | IDLE_W | Idle cycles before vector power-down; 0 disables |
| core_state | output | 2 | 00 run, 01 light idle, 10 deep idle |
| vec_pwr_en | output | 1 | Vector-unit power enable |
| vec_busy | output | 1 | Vector unit waking, not yet usable |

## Verification
The bench targets off-by-one timing at both counters. A delay timer that also counted ticks in run, or that compared against D-1, would reach deep idle one tick early. An inactivity counter that missed the reload would power down during use. A wake in the same cycle as the expiring tick must win: a design that let the tick win would wrongly land in deep idle. The re-entry check shows that a timer which is not cleared on wake shortens the next idle period. The wake-latency window is measured exactly. The cycle after busy falls must start a fresh inactivity count, so a stale counter would cut power too soon.

// File: rtl/idle_pwr_pkg.sv
// Package: shared state encodings for the idle power sequencer.
// Assumes: the core_state encoding is visible at the top ports and must stay fixed.
package idle_pwr_pkg;

    typedef enum logic [1:0] {
        CORE_RUN   = 2'b00,
        CORE_LIGHT = 2'b01,
        CORE_DEEP  = 2'b10
    } core_st_e;

    typedef enum logic [1:0] {
        VU_ON     = 2'b00,
        VU_OFF    = 2'b01,
        VU_WAKING = 2'b10
    } vu_st_e;

endpackage

// File: rtl/core_idle_fsm.sv
// Module: core_idle_fsm
// Walks the core through run, light idle and deep idle. A tick counter
// runs only in light idle; once deep_delay ticks have passed, the state
// becomes deep idle. Assumes tb_tick is a single-cycle pulse in the clk domain.
module core_idle_fsm
    import idle_pwr_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DLY_W-1:0] delay,
    input  logic             idle_req,
    input  logic             wake_evt,
    output core_st_e         state
);

    localparam int CW = DLY_W + 1;

    core_st_e         state_nx;
    logic [DLY_W-1:0] tick_cnt;
    logic [DLY_W-1:0] tick_cnt_nx;
    logic [CW-1:0]    cnt_inc;
    logic             expire;

    // Purpose: the count this tick would reach, and whether that ends the delay.
    always_comb begin
        cnt_inc = {1'b0, tick_cnt} + CW'(1);
        expire  = (delay != '0) && tick && (cnt_inc >= {1'b0, delay});
    end

    // Purpose: next state and next tick count; wake always wins.
    always_comb begin
        state_nx    = state;
        tick_cnt_nx = tick_cnt;
        unique case (state)
            CORE_RUN: begin
                tick_cnt_nx = '0;
                if (idle_req && !wake_evt) state_nx = CORE_LIGHT;
            end
            CORE_LIGHT: begin
                if (wake_evt) begin
                    state_nx    = CORE_RUN;
                    tick_cnt_nx = '0;
                end else if (expire) begin
                    state_nx    = CORE_DEEP;
                    tick_cnt_nx = '0;
                end else if (tick && delay != '0) begin
                    tick_cnt_nx = cnt_inc[DLY_W-1:0];
                end
            end
            CORE_DEEP: begin
                tick_cnt_nx = '0;
                if (wake_evt) state_nx = CORE_RUN;
            end
            default: begin
                state_nx    = CORE_RUN;
                tick_cnt_nx = '0;
            end
        endcase
    end

    // Purpose: state and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CORE_RUN;
            tick_cnt <= '0;
        end else begin
            state    <= state_nx;
            tick_cnt <= tick_cnt_nx;
        end
    end

endmodule

// File: rtl/vec_pwr_ctl.sv
// Module: vec_pwr_ctl
// Powers down the vector unit after a run of idle cycles. It powers the unit
// back up on demand and reports busy for a fixed wake latency.
// Assumes vec_issue is high only in cycles where a vector instruction executes.
module vec_pwr_ctl
    import idle_pwr_pkg::*;
#(
    parameter int IDLE_W   = 12,
    parameter int WAKE_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [IDLE_W-1:0] limit,
    output logic              pwr_en,
    output logic              busy
);

    localparam int IW   = IDLE_W + 1;
    localparam int WL_W = (WAKE_LAT < 1) ? 1 : $clog2(WAKE_LAT + 1);

    vu_st_e            state, state_nx;
    logic [IDLE_W-1:0] idle_cnt, idle_cnt_nx;
    logic [WL_W-1:0]   wake_cnt, wake_cnt_nx;
    logic [IW-1:0]     idle_inc;
    logic [WL_W-1:0]   wake_inc;
    logic              wake_done;

    // Purpose: incremented counts and end of the wake window.
    always_comb begin
        idle_inc = {1'b0, idle_cnt} + IW'(1);
        wake_inc = wake_cnt + WL_W'(1);
    end

    // Purpose: pick the wake-window variant from WAKE_LAT.
    generate
        if (WAKE_LAT < 1) begin : g_no_lat
            assign wake_done = 1'b1;
        end else begin : g_lat
            assign wake_done = (wake_inc == WL_W'(WAKE_LAT));
        end
    endgenerate

    // Purpose: next power state and counters.
    always_comb begin
        state_nx    = state;
        idle_cnt_nx = idle_cnt;
        wake_cnt_nx = wake_cnt;
        unique case (state)
            VU_ON: begin
                if (issue || limit == '0) begin
                    idle_cnt_nx = '0;
                end else if (idle_inc >= {1'b0, limit}) begin
                    state_nx    = VU_OFF;
                    idle_cnt_nx = '0;
                end else begin
                    idle_cnt_nx = idle_inc[IDLE_W-1:0];
                end
            end
            VU_OFF: begin
                if (issue) begin
                    state_nx    = VU_WAKING;
                    wake_cnt_nx = '0;
                end
            end
            VU_WAKING: begin
                if (wake_done) begin
                    state_nx    = VU_ON;
                    idle_cnt_nx = '0;
                    wake_cnt_nx = '0;
                end else begin
                    wake_cnt_nx = wake_inc;
                end
            end
            default: state_nx = VU_ON;
        endcase
    end

    // Purpose: state and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= VU_ON;
            idle_cnt <= '0;
            wake_cnt <= '0;
        end else begin
            state    <= state_nx;
            idle_cnt <= idle_cnt_nx;
            wake_cnt <= wake_cnt_nx;
        end
    end

    // Purpose: decode outputs from the registered state.
    always_comb begin
        pwr_en = (state != VU_OFF);
        busy   = (state == VU_WAKING);
    end

endmodule

// File: rtl/idle_pwr_seq.sv
// Module: idle_pwr_seq (top)
// Joins the core idle state machine and the vector-unit power controller.
// Assumes all inputs are synchronous to clk. Gating itself is done outside.
module idle_pwr_seq
    import idle_pwr_pkg::*;
#(
    parameter int DLY_W    = 16,
    parameter int IDLE_W   = 12,
    parameter int WAKE_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_tick,
    input  logic [DLY_W-1:0]  deep_delay,
    input  logic              idle_req,
    input  logic              wake_evt,
    input  logic              vec_issue,
    input  logic [IDLE_W-1:0] vec_idle_limit,
    output logic [1:0]        core_state,
    output logic              vec_pwr_en,
    output logic              vec_busy
);

    core_st_e core_st;

    core_idle_fsm #(.DLY_W(DLY_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tb_tick),
        .delay    (deep_delay),
        .idle_req (idle_req),
        .wake_evt (wake_evt),
        .state    (core_st)
    );

    vec_pwr_ctl #(.IDLE_W(IDLE_W), .WAKE_LAT(WAKE_LAT)) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (vec_issue),
        .limit  (vec_idle_limit),
        .pwr_en (vec_pwr_en),
        .busy   (vec_busy)
    );

    // Purpose: present the core state as a plain 2-bit code.
    always_comb core_state = core_st;

endmodule

// File: rtl/idle_pwr_seq_chk.sv
// Module: idle_pwr_seq_chk
// Checks the sequencer's port behaviour over time. It is attached to every
// idle_pwr_seq instance by the bind below.
module idle_pwr_seq_chk #(
    parameter int DLY_W  = 16,
    parameter int IDLE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tb_tick,
    input logic [DLY_W-1:0]  deep_delay,
    input logic              idle_req,
    input logic              wake_evt,
    input logic              vec_issue,
    input logic [IDLE_W-1:0] vec_idle_limit,
    input logic [1:0]        core_state,
    input logic              vec_pwr_en,
    input logic              vec_busy
);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (core_state == 2'b00 && vec_pwr_en && !vec_busy));

    a_r2_run_to_light: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == 2'b00 && idle_req && !wake_evt) |=> core_state == 2'b01);

    a_r3_deep_via_light: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == 2'b10 && $past(core_state) != 2'b10) |-> $past(core_state) == 2'b01);

    a_r4_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state != 2'b00 && wake_evt) |=> core_state == 2'b00);

    a_r5_zero_delay_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == 2'b01 && deep_delay == '0 && !wake_evt) |=> core_state == 2'b01);

    a_r6_wake_beats_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == 2'b00 && wake_evt) |=> core_state == 2'b00);

    a_r8_issue_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_pwr_en && !vec_busy && vec_issue) |=> vec_pwr_en);

    a_r9_no_limit_no_off: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_pwr_en && vec_idle_limit == '0) |=> vec_pwr_en);

    a_r10_wake_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_pwr_en && vec_issue) |=> (vec_pwr_en && vec_busy));

    a_r10_busy_powered: assert property (@(posedge clk) disable iff (!rst_n)
        vec_busy |-> vec_pwr_en);

endmodule

bind idle_pwr_seq idle_pwr_seq_chk #(.DLY_W(DLY_W), .IDLE_W(IDLE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tb_tick        (tb_tick),
    .deep_delay     (deep_delay),
    .idle_req       (idle_req),
    .wake_evt       (wake_evt),
    .vec_issue      (vec_issue),
    .vec_idle_limit (vec_idle_limit),
    .core_state     (core_state),
    .vec_pwr_en     (vec_pwr_en),
    .vec_busy       (vec_busy)
);

// File: tb/sim_idle_pwr_seq.sv
// Bench for idle_pwr_seq: a table walk of core state steps, then directed tests.
module sim_idle_pwr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DLY_W      = 16;
    localparam int IDLE_W     = 12;
    localparam int WAKE_LAT   = 4;
    localparam int N_STEPS    = 18;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              tb_tick;
    logic [DLY_W-1:0]  deep_delay;
    logic              idle_req;
    logic              wake_evt;
    logic              vec_issue;
    logic [IDLE_W-1:0] vec_idle_limit;
    logic [1:0]        core_state;
    logic              vec_pwr_en;
    logic              vec_busy;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    idle_pwr_seq #(.DLY_W(DLY_W), .IDLE_W(IDLE_W), .WAKE_LAT(WAKE_LAT)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .tb_tick        (tb_tick),
        .deep_delay     (deep_delay),
        .idle_req       (idle_req),
        .wake_evt       (wake_evt),
        .vec_issue      (vec_issue),
        .vec_idle_limit (vec_idle_limit),
        .core_state     (core_state),
        .vec_pwr_en     (vec_pwr_en),
        .vec_busy       (vec_busy)
    );

    // Entry: {idle_req, wake_evt, tb_tick, expected core_state, requirement}.
    // deep_delay = 3 throughout the walk.
    localparam logic [8:0] CORE_TBL [N_STEPS] = '{
        {3'b001, 2'b00, 4'd2},  // R2 tick in run not counted
        {3'b100, 2'b01, 4'd2},  // R2 enter light idle
        {3'b001, 2'b01, 4'd3},  // R3 tick 1
        {3'b000, 2'b01, 4'd3},  // R3 no tick
        {3'b001, 2'b01, 4'd3},  // R3 tick 2
        {3'b001, 2'b10, 4'd3},  // R3 tick 3 -> deep
        {3'b001, 2'b10, 4'd3},  // R3 stays deep
        {3'b010, 2'b00, 4'd4},  // R4 wake from deep
        {3'b100, 2'b01, 4'd2},  // R2 re-enter light
        {3'b001, 2'b01, 4'd3},  // R3 tick 1
        {3'b001, 2'b01, 4'd3},  // R3 tick 2
        {3'b011, 2'b00, 4'd4},  // R4 wake beats the expiring tick
        {3'b100, 2'b01, 4'd2},  // R2 re-enter light
        {3'b001, 2'b01, 4'd4},  // R4 count was cleared: tick 1
        {3'b001, 2'b01, 4'd4},  // R4 tick 2
        {3'b001, 2'b10, 4'd3},  // R3 tick 3 -> deep
        {3'b110, 2'b00, 4'd4},  // R4 wake from deep
        {3'b110, 2'b00, 4'd6}   // R6 wake beats idle_req in run
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: inputs were set away from the edge; sample after the edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        tb_tick   = 1'b0;
        idle_req  = 1'b0;
        wake_evt  = 1'b0;
        vec_issue = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clear_inputs();
        step();
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        deep_delay     = DLY_W'(3);
        vec_idle_limit = '0;
        do_reset();
        // R1 reset state
        check("R1 core_state", core_state, 0);
        check("R1 vec_pwr_en", vec_pwr_en, 1);
        check("R1 vec_busy",   vec_busy,   0);

        // Table walk, core state sequence.
        for (int i = 0; i < N_STEPS; i++) begin
            {idle_req, wake_evt, tb_tick} = CORE_TBL[i][8:6];
            step();
            check($sformatf("R%0d step %0d", CORE_TBL[i][3:0], i),
                  core_state, int'(CORE_TBL[i][5:4]));
        end
        clear_inputs();
        step();

        // R5: a zero delay never reaches deep idle.
        deep_delay = '0;
        idle_req   = 1'b1;
        step();
        idle_req = 1'b0;
        tb_tick  = 1'b1;
        repeat (20) step();
        check("R5 zero delay holds light", core_state, 1);
        tb_tick  = 1'b0;
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
        check("R4 wake from light", core_state, 0);

        // R1: reset taken while in deep idle.
        deep_delay = DLY_W'(1);
        idle_req   = 1'b1;
        step();
        idle_req = 1'b0;
        tb_tick  = 1'b1;
        step();
        tb_tick = 1'b0;
        check("R3 delay of one tick", core_state, 2);
        do_reset();
        check("R1 reset from deep", core_state, 0);

        // R7: power-down after exactly N idle edges.
        vec_idle_limit = IDLE_W'(5);
        vec_issue      = 1'b1;
        step();
        vec_issue = 1'b0;
        repeat (4) step();
        check("R7 still powered after N-1", vec_pwr_en, 1);
        step();
        check("R7 off after N", vec_pwr_en, 0);

        // R10: wake on demand, busy for WAKE_LAT cycles.
        vec_issue = 1'b1;
        step();
        vec_issue = 1'b0;
        check("R10 power back", vec_pwr_en, 1);
        check("R10 busy set",   vec_busy,   1);
        repeat (WAKE_LAT - 1) step();
        check("R10 busy through latency", vec_busy, 1);
        step();
        check("R10 busy cleared", vec_busy, 0);
        repeat (4) step();
        check("R10 fresh count after wake", vec_pwr_en, 1);
        step();
        check("R10 off after fresh N", vec_pwr_en, 0);

        // R8: an issue pulse reloads the count.
        vec_issue = 1'b1;
        step();
        vec_issue = 1'b0;
        repeat (WAKE_LAT) step();
        repeat (3) step();
        vec_issue = 1'b1;
        step();
        vec_issue = 1'b0;
        repeat (4) step();
        check("R8 reload keeps power", vec_pwr_en, 1);
        step();
        check("R8 off after reload span", vec_pwr_en, 0);

        // R9: a zero limit never powers down.
        vec_idle_limit = '0;
        vec_issue      = 1'b1;
        step();
        vec_issue = 1'b0;
        repeat (WAKE_LAT) step();
        repeat (40) step();
        check("R9 zero limit stays on", vec_pwr_en, 1);
        check("R9 not busy", vec_busy, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule